// File: doc/BRIEF.md
# Accumulator Alter-and-Skip Micro-Operation Unit

This unit carries out one combined alter-and-skip statement on a single 16-bit accumulator word and the one-bit extend flag. A statement may alter the accumulator (clear, complement or fill with ones) and alter the extend flag in the same way. It may also increment the accumulator and ask for any mix of four tests: extend flag is zero, sign bit is zero, least significant bit is zero, and whole word is zero. A reverse flag inverts the sense of the tests. The caller selects which accumulator to present, so the unit never sees two accumulators at once. The caller writes the results back, and the skip request tells the sequencer to pass over the next instruction.

The micro-operations act in a fixed order. The accumulator alter comes first. The extend-zero test is next, then the extend alter, then the sign and low-bit tests, then the increment, and the zero test comes last. Each test therefore sees the word or flag as it stands at its own place in that chain. When the reverse flag is clear, the unit skips if any selected test holds. When the reverse flag is set, the unit skips only if no selected test holds. With no test selected, the reverse flag alone always skips.

When `exec` is high, the inputs are evaluated and the results are captured into output registers at the next rising clock edge. When `exec` is low, the outputs hold.

Top module: `altsk_unit`

## Requirements
- R1: A synchronous active-high reset drives `acc_out`, `e_out` and `skip_out` to 0.
- R2: Results appear on the outputs at the first rising edge after `exec` is sampled high. While `exec` is low, all outputs keep their values.
- R3: `acc_op` selects the accumulator alter as follows: 0 keeps the word, 1 clears it to 0x0000, 2 inverts every bit, and 3 sets it to 0xFFFF.
- R4: `e_op` uses the same encoding on the extend flag: 0 keeps it, 1 clears it, 2 inverts it, and 3 sets it.
- R5: The extend-zero test (`tst_ez`) looks at `e_in` before the extend alter is applied.
- R6: The sign test (`tst_sign`, true when bit 15 is 0) and the low-bit test (`tst_lsb`, true when bit 0 is 0) look at the word after the accumulator alter and before the increment.
- R7: `do_inc` adds one to the altered word, and 0xFFFF wraps to 0x0000.
- R8: The zero test (`tst_zero`) looks at the word after the increment.
- R9: With `rev_skip` low, `skip_out` is 1 exactly when at least one selected test is true. It is 0 when no test is selected.
- R10: With `rev_skip` high and no test selected, `skip_out` is 1.
- R11: With `rev_skip` high and at least one test selected, `skip_out` is 1 only when every selected test is false. For example, with the sign and low-bit tests both selected, the unit skips only when bit 15 and bit 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec | input | 1 | Evaluate the statement and capture its results |
| acc_in | input | 16 | Selected accumulator word before the statement |
| e_in | input | 1 | Extend flag before the statement |
| acc_op | input | 2 | Accumulator alter: 0 keep, 1 clear, 2 invert, 3 all ones |
| e_op | input | 2 | Extend alter: 0 keep, 1 clear, 2 invert, 3 set |
| tst_ez | input | 1 | Select the extend-is-zero test |
| tst_sign | input | 1 | Select the sign-bit-is-zero test |
| tst_lsb | input | 1 | Select the low-bit-is-zero test |
| do_inc | input | 1 | Increment the accumulator |
| tst_zero | input | 1 | Select the word-is-zero test |
| rev_skip | input | 1 | Reverse the sense of the skip |
| acc_out | output | 16 | Updated accumulator |
| e_out | output | 1 | Updated extend flag |
| skip_out | output | 1 | Skip request for the next instruction |

## Verification
Some properties are checked by assertions on every cycle: outputs hold while `exec` is low, the lone reverse flag always skips, no skip occurs with no test and no reverse, a zero result under the zero test always skips, the incrementer wraps, and the extend flag obeys set and clear. Only the bench's vectors can show that each test samples its word at the right place in the chain. For example, the extend test must see the old flag, and the low-bit test must see the word before the increment. The vectors also exercise the reversed AND of two tests and the exact inverted values.

// File: rtl/altsk_pkg.sv
package altsk_pkg;

    localparam int DATA_W = 16;
    localparam int N_TESTS = 4;

    typedef enum logic [1:0] {
        ALT_KEEP  = 2'd0,
        ALT_CLEAR = 2'd1,
        ALT_FLIP  = 2'd2,
        ALT_FILL  = 2'd3
    } alter_e;

    typedef struct packed {
        logic ez;
        logic sign;
        logic lsb;
        logic zero;
        logic rev;
    } test_sel_t;

    // Apply an alter code to a single flag bit.
    function automatic logic alter_bit(input alter_e op, input logic v);
        logic r;
        case (op)
            ALT_CLEAR: r = 1'b0;
            ALT_FLIP:  r = ~v;
            ALT_FILL:  r = 1'b1;
            default:   r = v;
        endcase
        return r;
    endfunction

    // Fold the test condition vector into a skip decision.
    function automatic logic fold_skip(input logic [N_TESTS-1:0] hit, input logic rev);
        logic any_hit;
        any_hit = |hit;
        return rev ? ~any_hit : any_hit;
    endfunction

endpackage

// File: rtl/altsk_acc_path.sv
module altsk_acc_path
    import altsk_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] acc_in,
    input  alter_e       op,
    input  logic         inc,
    output logic [W-1:0] acc_mid,
    output logic [W-1:0] acc_fin
);

    localparam logic [W-1:0] ONE_W = {{(W-1){1'b0}}, 1'b1};

    // Stage one: accumulator alter, applied bit by bit.
    for (genvar i = 0; i < W; i++) begin : g_alter
        assign acc_mid[i] = alter_bit(op, acc_in[i]);
    end

    // Stage two: optional increment, wrapping at the word width.
    always_comb begin
        acc_fin = acc_mid;
        if (inc) begin
            acc_fin = acc_mid + ONE_W;
        end
    end

endmodule

// File: rtl/altsk_e_path.sv
module altsk_e_path
    import altsk_pkg::*;
(
    input  logic   e_in,
    input  alter_e op,
    output logic   e_was_zero,
    output logic   e_fin
);

    // The extend test sees the flag before the alter.
    assign e_was_zero = ~e_in;
    assign e_fin      = alter_bit(op, e_in);

endmodule

// File: rtl/altsk_skip_eval.sv
module altsk_skip_eval
    import altsk_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  test_sel_t    sel,
    input  logic         e_was_zero,
    input  logic [W-1:0] acc_mid,
    input  logic [W-1:0] acc_fin,
    output logic         skip
);

    localparam int IDX_EZ   = 0;
    localparam int IDX_SIGN = 1;
    localparam int IDX_LSB  = 2;
    localparam int IDX_ZERO = 3;

    logic [N_TESTS-1:0] cond;
    logic [N_TESTS-1:0] enable;
    logic [N_TESTS-1:0] hit;

    // Each condition is taken at its own place in the chain.
    assign cond[IDX_EZ]   = e_was_zero;
    assign cond[IDX_SIGN] = ~acc_mid[W-1];
    assign cond[IDX_LSB]  = ~acc_mid[0];
    assign cond[IDX_ZERO] = (acc_fin == '0);

    assign enable[IDX_EZ]   = sel.ez;
    assign enable[IDX_SIGN] = sel.sign;
    assign enable[IDX_LSB]  = sel.lsb;
    assign enable[IDX_ZERO] = sel.zero;

    for (genvar t = 0; t < N_TESTS; t++) begin : g_hit
        assign hit[t] = enable[t] & cond[t];
    end

    // Reverse: skip only when no selected test holds (an empty set skips).
    assign skip = fold_skip(hit, sel.rev);

endmodule

// File: rtl/altsk_unit.sv
module altsk_unit
    import altsk_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         exec,
    input  logic [W-1:0] acc_in,
    input  logic         e_in,
    input  logic [1:0]   acc_op,
    input  logic [1:0]   e_op,
    input  logic         tst_ez,
    input  logic         tst_sign,
    input  logic         tst_lsb,
    input  logic         do_inc,
    input  logic         tst_zero,
    input  logic         rev_skip,
    output logic [W-1:0] acc_out,
    output logic         e_out,
    output logic         skip_out
);

    alter_e    acc_alt;
    alter_e    e_alt;
    test_sel_t sel;
    logic [W-1:0] acc_mid;
    logic [W-1:0] acc_fin;
    logic         e_was_zero;
    logic         e_fin;
    logic         skip_c;

    assign acc_alt = alter_e'(acc_op);
    assign e_alt   = alter_e'(e_op);
    assign sel     = '{ez: tst_ez, sign: tst_sign, lsb: tst_lsb,
                       zero: tst_zero, rev: rev_skip};

    altsk_acc_path #(.W(W)) u_acc (
        .acc_in  (acc_in),
        .op      (acc_alt),
        .inc     (do_inc),
        .acc_mid (acc_mid),
        .acc_fin (acc_fin)
    );

    altsk_e_path u_e (
        .e_in       (e_in),
        .op         (e_alt),
        .e_was_zero (e_was_zero),
        .e_fin      (e_fin)
    );

    altsk_skip_eval #(.W(W)) u_skip (
        .sel        (sel),
        .e_was_zero (e_was_zero),
        .acc_mid    (acc_mid),
        .acc_fin    (acc_fin),
        .skip       (skip_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_out  <= '0;
            e_out    <= 1'b0;
            skip_out <= 1'b0;
        end else if (exec) begin
            acc_out  <= acc_fin;
            e_out    <= e_fin;
            skip_out <= skip_c;
        end
    end

    logic no_test;
    assign no_test = ~(tst_ez | tst_sign | tst_lsb | tst_zero);

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !exec |=> ($stable(acc_out) && $stable(e_out) && $stable(skip_out))); // R2

    AST_E_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (exec && e_op == 2'd1) |=> !e_out); // R4

    AST_E_SET: assert property (@(posedge clk) disable iff (rst)
        (exec && e_op == 2'd3) |=> e_out); // R4

    AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (exec && acc_op == 2'd0 && do_inc && acc_in == '1) |=> (acc_out == '0)); // R7

    AST_ZERO_SKIPS: assert property (@(posedge clk) disable iff (rst)
        (exec && tst_zero && !rev_skip) |=> (acc_out != '0 || skip_out)); // R8

    AST_QUIET_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
        (exec && no_test && !rev_skip) |=> !skip_out); // R9

    AST_REV_ALONE: assert property (@(posedge clk) disable iff (rst)
        (exec && no_test && rev_skip) |=> skip_out); // R10

endmodule

// File: tb/altsk_unit_bench.sv
module altsk_unit_bench;

    typedef struct packed {
        logic [15:0] a;
        logic        e;
        logic [1:0]  aop;
        logic [1:0]  eop;
        logic        ez;
        logic        sg;
        logic        lb;
        logic        inc;
        logic        zr;
        logic        rv;
        logic [15:0] xa;
        logic        xe;
        logic        xs;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        // a        e     aop   eop   ez sg lb in zr rv  xa        xe    xs   req
        '{16'h1234,1'b0,2'd1,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,4'd3},  // R3 clear
        '{16'h00FF,1'b0,2'd2,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'hFF00,1'b0,1'b0,4'd3},  // R3 invert
        '{16'h1234,1'b0,2'd3,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'hFFFF,1'b0,1'b0,4'd3},  // R3 fill
        '{16'h5555,1'b1,2'd0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h5555,1'b0,1'b0,4'd4},  // R4 clear
        '{16'h5555,1'b0,2'd0,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h5555,1'b1,1'b0,4'd4},  // R4 invert
        '{16'h5555,1'b0,2'd0,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h5555,1'b1,1'b0,4'd4},  // R4 set
        '{16'h0001,1'b0,2'd0,2'd3,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0001,1'b1,1'b1,4'd5},  // R5 old E=0
        '{16'h0001,1'b1,2'd0,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0001,1'b0,1'b0,4'd5},  // R5 old E=1
        '{16'h7FFF,1'b0,2'd2,2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h8000,1'b0,1'b0,4'd6},  // R6 sign after alter
        '{16'h8001,1'b0,2'd0,2'd0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,16'h8002,1'b0,1'b0,4'd6},  // R6 before inc
        '{16'hFFFF,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0,4'd7},  // R7 wrap
        '{16'hFFFF,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,16'h0000,1'b0,1'b1,4'd8},  // R8 zero after inc
        '{16'h0000,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,16'h0001,1'b0,1'b0,4'd8},  // R8 nonzero after inc
        '{16'h0004,1'b0,2'd0,2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,16'h0004,1'b0,1'b1,4'd9},  // R9 any holds
        '{16'h8001,1'b0,2'd0,2'd0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,16'h8001,1'b0,1'b0,4'd9},  // R9 none holds
        '{16'h1111,1'b1,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h1111,1'b1,1'b1,4'd10}, // R10
        '{16'h8001,1'b0,2'd0,2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,16'h8001,1'b0,1'b1,4'd11}, // R11 both set
        '{16'h8000,1'b0,2'd0,2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,16'h8000,1'b0,1'b0,4'd11}, // R11 lsb zero
        '{16'h0000,1'b0,2'd2,2'd0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,16'h0000,1'b0,1'b0,4'd11}, // R11 zero holds
        '{16'h3333,1'b1,2'd0,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h3333,1'b0,1'b0,4'd9}   // R9 R5 E test false
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec = 1'b0;
    logic [15:0] acc_in = '0;
    logic        e_in = 1'b0;
    logic [1:0]  acc_op = '0;
    logic [1:0]  e_op = '0;
    logic        tst_ez = 1'b0;
    logic        tst_sign = 1'b0;
    logic        tst_lsb = 1'b0;
    logic        do_inc = 1'b0;
    logic        tst_zero = 1'b0;
    logic        rev_skip = 1'b0;
    logic [15:0] acc_out;
    logic        e_out;
    logic        skip_out;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    altsk_unit u_altsk_unit (
        .clk(clk), .rst(rst), .exec(exec), .acc_in(acc_in), .e_in(e_in),
        .acc_op(acc_op), .e_op(e_op), .tst_ez(tst_ez), .tst_sign(tst_sign),
        .tst_lsb(tst_lsb), .do_inc(do_inc), .tst_zero(tst_zero),
        .rev_skip(rev_skip), .acc_out(acc_out), .e_out(e_out), .skip_out(skip_out)
    );

    task automatic check(input string tag, input logic [15:0] xa, input logic xe, input logic xs);
        n_run++;
        if (acc_out !== xa || e_out !== xe || skip_out !== xs) begin
            n_fail++;
            $display("FAIL %s: acc=%h e=%b skip=%b, expected acc=%h e=%b skip=%b",
                     tag, acc_out, e_out, skip_out, xa, xe, xs);
        end
    endtask

    task automatic drive(input vec_t v);
        acc_in = v.a; e_in = v.e; acc_op = v.aop; e_op = v.eop;
        tst_ez = v.ez; tst_sign = v.sg; tst_lsb = v.lb; do_inc = v.inc;
        tst_zero = v.zr; rev_skip = v.rv;
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 16'h0000, 1'b0, 1'b0);
        rst = 1'b0;

        // Vector table: drive on a falling edge, sample one falling edge later.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            exec = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].xa, VEC[i].xe, VEC[i].xs);
        end

        // R2: capture one result, then hold while exec is low and inputs change.
        drive(VEC[13]);
        exec = 1'b1;
        @(negedge clk);
        check("R2 capture", 16'h0004, 1'b0, 1'b1);
        exec = 1'b0;
        drive(VEC[2]);
        rev_skip = 1'b0;
        @(negedge clk);
        check("R2 hold cycle 1", 16'h0004, 1'b0, 1'b1);
        @(negedge clk);
        check("R2 hold cycle 2", 16'h0004, 1'b0, 1'b1);

        // R2: first edge after exec rises updates the outputs.
        exec = 1'b1;
        @(negedge clk);
        check("R2 update after hold", 16'hFFFF, 1'b0, 1'b0);

        // R1: reset in mid-run clears nonzero outputs.
        drive(VEC[15]);
        @(negedge clk);
        check("R10 before reset", 16'h1111, 1'b1, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", 16'h0000, 1'b0, 1'b0);
        rst = 1'b0;
        exec = 1'b0;
        @(negedge clk);
        check("R1 reset then idle", 16'h0000, 1'b0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule